// File: doc/BRIEF.md
# Load Result and Fault Unit

This block completes the data side of a processor load. It takes a load request with its effective address, access size, destination register index and three qualifiers (unsigned, acquire, reservation), decides whether the access may go to memory, and turns the memory reply into either a 64-bit register writeback or a trap request. A trap request carries a cause code and the faulting effective address.

Acquire and reservation loads must be naturally aligned. When such a load is misaligned, the block reports a misaligned-address trap and never asks memory. Ordinary loads skip the alignment check and go to memory whatever their address. A memory reply flagged as faulty becomes an access-fault trap. Either kind of trap suppresses the register write. Reservation loads always sign-extend and allow only word and doubleword sizes. Any other size on a reservation load raises a one-cycle internal-error pulse instead.

The unit keeps one load in flight. It lowers its ready output while a memory reply is outstanding and ignores requests during that time. All outputs come from registers.

Top module: `load_result_unit`

## Requirements
- R1: During and after reset, `wb_valid`, `trap_valid`, `int_err` and `mem_req_valid` are low and `req_ready` is high.
- R2: Size codes are 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. With `req_unsigned` set on a non-reservation load, the byte, halfword and word results are the low bytes of the memory data, zero-extended to 64 bits.
- R3: With `req_unsigned` clear, byte, halfword and word results are sign-extended from their top bit. A doubleword result equals the memory data unchanged.
- R4: An acquire or reservation load whose address is not a multiple of its size in bytes yields, one cycle after acceptance, `trap_valid` with `trap_cause` = 4 and `trap_tval` = the address. No memory request and no writeback follow.
- R5: A load with neither the acquire flag nor the reservation flag set issues a memory request whatever its alignment.
- R6: A memory reply with `mem_rsp_fault` set yields, one cycle later, `trap_valid` with `trap_cause` = 5 and `trap_tval` = the load address, and no writeback.
- R7: A reservation load sign-extends its result even when `req_unsigned` is set.
- R8: A reservation load of byte or halfword size yields a one-cycle `int_err` pulse one cycle after acceptance. It causes no memory request, no trap and no writeback.
- R9: A completed load raises `wb_valid` for exactly one cycle, one cycle after the reply, with `wb_rd` equal to the request's register index.
- R10: An issued memory request is a one-cycle `mem_req_valid` pulse, one cycle after acceptance, carrying the request's address and size. `req_ready` stays low until the reply, and requests offered while it is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | ADDR_W | Effective address |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 double |
| req_unsigned | input | 1 | Zero-extend the result |
| req_acquire | input | 1 | Acquire-ordered load |
| req_reserve | input | 1 | Reservation load |
| req_rd | input | REG_W | Destination register index |
| mem_req_valid | output | 1 | Memory read request pulse |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_req_size | output | 2 | Memory read size code |
| mem_rsp_valid | input | 1 | Memory reply strobe |
| mem_rsp_data | input | XLEN | Reply data, right-aligned |
| mem_rsp_fault | input | 1 | Reply reports an access fault |
| wb_valid | output | 1 | Register writeback pulse |
| wb_rd | output | REG_W | Writeback register index |
| wb_data | output | XLEN | Extended load result |
| trap_valid | output | 1 | Trap request pulse |
| trap_cause | output | CAUSE_W | 4 misaligned, 5 access fault |
| trap_tval | output | ADDR_W | Faulting effective address |
| int_err | output | 1 | Unsupported reservation size pulse |

## Verification
The bench builds the unit with its default parameters: a 64-bit data path, 64-bit addresses, 5-bit register indices and 4-bit cause codes. The full doubleword path and every extension boundary are therefore exercised. Randomised address low bits and flag mixes cover each alignment offset for every size, both with and without the alignment rule. Varying reply latencies, faults, and requests offered while the unit is busy cover the one-outstanding-load behaviour.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } lru_state_e;
endpackage

// File: rtl/lru_align_check.sv
module lru_align_check #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              misaligned
);
  localparam int OFS_W = 3;

  logic [OFS_W-1:0] low_mask;

  always_comb begin
    for (int b = 0; b < OFS_W; b++) begin
      low_mask[b] = (int'(size) > b);
    end
    misaligned = |(addr[OFS_W-1:0] & low_mask);
  end
endmodule

// File: rtl/lru_extend.sv
module lru_extend #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  logic [1:0]      size,
  input  logic            sign_ext,
  output logic [XLEN-1:0] result
);
  localparam int NSUB = 3;

  logic [XLEN-1:0] sub_res [NSUB];

  genvar g;
  generate
    for (g = 0; g < NSUB; g++) begin : g_lane
      localparam int LW = 8 << g;
      logic top_bit;
      assign top_bit = sign_ext & raw[LW-1];
      assign sub_res[g] = {{(XLEN-LW){top_bit}}, raw[LW-1:0]};
    end
  endgenerate

  always_comb begin
    if (size == 2'd3) result = raw;
    else              result = sub_res[size];
  end
endmodule

// File: rtl/load_result_unit.sv
module load_result_unit
  import lru_pkg::*;
#(
  parameter int XLEN           = 64,
  parameter int ADDR_W         = 64,
  parameter int REG_W          = 5,
  parameter int CAUSE_W        = 4,
  parameter int CAUSE_MISALIGN = 4,
  parameter int CAUSE_ACCESS   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic               req_unsigned,
  input  logic               req_acquire,
  input  logic               req_reserve,
  input  logic [REG_W-1:0]   req_rd,
  output logic               mem_req_valid,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [1:0]         mem_req_size,
  input  logic               mem_rsp_valid,
  input  logic [XLEN-1:0]    mem_rsp_data,
  input  logic               mem_rsp_fault,
  output logic               wb_valid,
  output logic [REG_W-1:0]   wb_rd,
  output logic [XLEN-1:0]    wb_data,
  output logic               trap_valid,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [ADDR_W-1:0]  trap_tval,
  output logic               int_err
);
  localparam logic [CAUSE_W-1:0] C_MIS = CAUSE_W'(CAUSE_MISALIGN);
  localparam logic [CAUSE_W-1:0] C_ACC = CAUSE_W'(CAUSE_ACCESS);

  lru_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              sext_q;
  logic [REG_W-1:0]  rd_q;

  logic              req_mis;
  logic              needs_align;
  logic              bad_res_size;
  logic [XLEN-1:0]   ext_data;

  lru_align_check #(.ADDR_W(ADDR_W)) u_align (
    .addr       (req_addr),
    .size       (req_size),
    .misaligned (req_mis)
  );

  lru_extend #(.XLEN(XLEN)) u_ext (
    .raw      (mem_rsp_data),
    .size     (size_q),
    .sign_ext (sext_q),
    .result   (ext_data)
  );

  assign needs_align  = req_acquire | req_reserve;
  assign bad_res_size = req_reserve & ~req_size[1];
  assign req_ready    = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      addr_q        <= '0;
      size_q        <= '0;
      sext_q        <= 1'b0;
      rd_q          <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_size  <= '0;
      wb_valid      <= 1'b0;
      wb_rd         <= '0;
      wb_data       <= '0;
      trap_valid    <= 1'b0;
      trap_cause    <= '0;
      trap_tval     <= '0;
      int_err       <= 1'b0;
    end else begin
      mem_req_valid <= 1'b0;
      wb_valid      <= 1'b0;
      trap_valid    <= 1'b0;
      int_err       <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            size_q <= req_size;
            sext_q <= req_reserve | ~req_unsigned;
            rd_q   <= req_rd;
            if (bad_res_size) begin
              int_err <= 1'b1;
            end else if (needs_align && req_mis) begin
              trap_valid <= 1'b1;
              trap_cause <= C_MIS;
              trap_tval  <= req_addr;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= req_addr;
              mem_req_size  <= req_size;
              state_q       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            state_q <= ST_IDLE;
            if (mem_rsp_fault) begin
              trap_valid <= 1'b1;
              trap_cause <= C_ACC;
              trap_tval  <= addr_q;
            end else begin
              wb_valid <= 1'b1;
              wb_rd    <= rd_q;
              wb_data  <= ext_data;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lru_checker.sv
module lru_checker #(
  parameter int CAUSE_W        = 4,
  parameter int CAUSE_ACCESS   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               req_ready,
  input logic               mem_req_valid,
  input logic               mem_rsp_valid,
  input logic               mem_rsp_fault,
  input logic               wb_valid,
  input logic               trap_valid,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic               int_err
);
  // R9: writeback is a single-cycle pulse
  a_r9_wb_single: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> !wb_valid);

  // R10: memory request is a single-cycle pulse and marks the unit busy
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  a_r10_busy_on_req: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  a_r10_stay_busy: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !mem_rsp_valid) |=> !req_ready);

  // R6: a faulting reply while busy becomes an access-fault trap
  a_r6_fault_trap: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && mem_rsp_valid && mem_rsp_fault) |=>
      (trap_valid && !wb_valid && trap_cause == CAUSE_W'(CAUSE_ACCESS)));

  // R4: a trap never comes with a writeback
  a_r4_trap_no_wb: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> !wb_valid);

  // R8: internal error excludes every other outcome
  a_r8_err_alone: assert property (@(posedge clk) disable iff (rst)
    int_err |-> (!wb_valid && !trap_valid && !mem_req_valid));
endmodule

bind load_result_unit lru_checker #(
  .CAUSE_W      (CAUSE_W),
  .CAUSE_ACCESS (CAUSE_ACCESS)
) u_lru_checker (.*);

// File: tb/tb_load_result_unit.sv
`timescale 1ns/1ps
module tb_load_result_unit;
  localparam int XLEN = 64;
  localparam int AW   = 64;
  localparam int RW   = 5;
  localparam int CW   = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          req_unsigned, req_acquire, req_reserve;
  logic [RW-1:0] req_rd;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic [1:0]    mem_req_size;
  logic          mem_rsp_valid;
  logic [XLEN-1:0] mem_rsp_data;
  logic          mem_rsp_fault;
  logic          wb_valid;
  logic [RW-1:0] wb_rd;
  logic [XLEN-1:0] wb_data;
  logic          trap_valid;
  logic [CW-1:0] trap_cause;
  logic [AW-1:0] trap_tval;
  logic          int_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  load_result_unit dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_acquire(req_acquire),
    .req_reserve(req_reserve), .req_rd(req_rd),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_fault(mem_rsp_fault),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_tval(trap_tval),
    .int_err(int_err)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expect_data(input logic [63:0] raw,
      input logic [1:0] sz, input bit uns, input bit res);
    bit sx;
    sx = res || !uns;
    case (sz)
      2'd0: return sx ? {{56{raw[7]}},  raw[7:0]}  : {56'd0, raw[7:0]};
      2'd1: return sx ? {{48{raw[15]}}, raw[15:0]} : {48'd0, raw[15:0]};
      2'd2: return sx ? {{32{raw[31]}}, raw[31:0]} : {32'd0, raw[31:0]};
      default: return raw;
    endcase
  endfunction

  task automatic run_load(input logic [63:0] addr, input logic [1:0] sz,
      input bit uns, input bit acq, input bit res, input logic [RW-1:0] rd,
      input logic [63:0] data, input bit fault, input int delay, input bit poke);
    bit mis;
    mis = (addr[2:0] & ((3'd1 << sz) - 3'd1)) != 3'd0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_size = sz; req_unsigned = uns;
    req_acquire = acq; req_reserve = res; req_rd = rd;
    @(negedge clk);
    req_valid = 1'b0;
    if (res && !sz[1]) begin
      check(int_err && !mem_req_valid && !trap_valid && !wb_valid, "R8 err pulse",
            {60'd0, int_err, mem_req_valid, trap_valid, wb_valid}, 64'h8);
      @(negedge clk);
      check(!int_err && !wb_valid && !mem_req_valid, "R8 err single",
            {63'd0, int_err}, 64'd0);
    end else if ((acq || res) && mis) begin
      check(trap_valid && trap_cause == 4'd4 && trap_tval == addr && !mem_req_valid
            && !wb_valid, "R4 misalign trap", trap_tval, addr);
      @(negedge clk);
      check(!mem_req_valid && !wb_valid, "R4 no access", {63'd0, mem_req_valid}, 64'd0);
    end else begin
      check(mem_req_valid && mem_req_addr == addr && mem_req_size == sz && !req_ready,
            (acq || res) ? "R10 mem req" : "R5 mem req", mem_req_addr, addr);
      for (int i = 0; i < delay; i++) begin
        if (poke) begin
          req_valid = 1'b1; req_addr = ~addr; req_size = 2'd0; req_reserve = 1'b0;
          req_acquire = 1'b0;
        end
        @(negedge clk);
        check(!mem_req_valid && !req_ready && !wb_valid, "R10 busy ignore",
              {62'd0, mem_req_valid, req_ready}, 64'd0);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = data; mem_rsp_fault = fault;
      @(negedge clk);
      mem_rsp_valid = 1'b0; req_valid = 1'b0;
      if (fault) begin
        check(trap_valid && trap_cause == 4'd5 && trap_tval == addr && !wb_valid,
              "R6 access fault", {trap_cause, trap_tval[59:0]}, {4'd5, addr[59:0]});
      end else begin
        check(wb_valid && wb_rd == rd, "R9 wb valid/rd", {58'd0, wb_valid, wb_rd},
              {58'd0, 1'b1, rd});
        check(wb_data == expect_data(data, sz, uns, res),
              res ? "R7 resv sign" : (uns ? "R2 zero ext" : "R3 sign ext"),
              wb_data, expect_data(data, sz, uns, res));
      end
      @(negedge clk);
      check(!wb_valid && !trap_valid && !mem_req_valid && req_ready, "R9 single pulse",
            {61'd0, wb_valid, trap_valid, mem_req_valid}, 64'd0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0; req_unsigned = 1'b0;
    req_acquire = 1'b0; req_reserve = 1'b0; req_rd = '0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_fault = 1'b0;
    repeat (3) @(negedge clk);
    check(!wb_valid && !trap_valid && !int_err && !mem_req_valid && req_ready,
          "R1 reset state", {59'd0, wb_valid, trap_valid, int_err, mem_req_valid,
          req_ready}, 64'd1);
    rst = 1'b0;
    @(negedge clk);
    check(!wb_valid && !trap_valid && !int_err && req_ready, "R1 after reset",
          {63'd0, req_ready}, 64'd1);

    // directed corner cases
    run_load(64'h1000, 2'd0, 1, 0, 0, 5'd1, 64'h0000_0000_0000_0080, 0, 0, 0); // R2 byte
    run_load(64'h1000, 2'd0, 0, 0, 0, 5'd2, 64'h0000_0000_0000_0080, 0, 1, 0); // R3 byte
    run_load(64'h1002, 2'd1, 1, 0, 0, 5'd3, 64'hFFFF_FFFF_FFFF_8001, 0, 0, 0); // R2 half
    run_load(64'h1004, 2'd2, 0, 0, 0, 5'd4, 64'h1234_5678_8765_4321, 0, 2, 0); // R3 word
    run_load(64'h1008, 2'd3, 1, 0, 0, 5'd5, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 0); // R3 dbl
    run_load(64'h1003, 2'd2, 0, 0, 0, 5'd6, 64'h0000_0000_7FFF_FFFF, 0, 1, 0); // R5
    run_load(64'h1003, 2'd2, 0, 1, 0, 5'd7, 64'h0, 0, 0, 0);                   // R4 acq
    run_load(64'h1004, 2'd3, 0, 0, 1, 5'd8, 64'h0, 0, 0, 0);                   // R4 res
    run_load(64'h1004, 2'd2, 1, 0, 1, 5'd9, 64'h0000_0000_8000_0000, 0, 1, 0); // R7
    run_load(64'h1000, 2'd0, 0, 0, 1, 5'd10, 64'h0, 0, 0, 0);                  // R8
    run_load(64'h1001, 2'd1, 0, 0, 1, 5'd11, 64'h0, 0, 0, 0);                  // R8
    run_load(64'h2000, 2'd3, 0, 1, 0, 5'd12, 64'h0, 1, 3, 0);                  // R6
    run_load(64'h2002, 2'd1, 0, 0, 0, 5'd13, 64'h0000_0000_0000_FFFF, 0, 3, 1); // R10

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, d;
      logic [1:0]  s;
      a = {$urandom, $urandom};
      d = {$urandom, $urandom};
      s = 2'($urandom);
      run_load(a, s, 1'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
               5'($urandom), d, ($urandom % 7) == 0, int'($urandom % 4),
               ($urandom % 5) == 0);
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule